// File: doc/BRIEF.md
# YCbCr 4:2:2 to 4:4:4 Chroma Upsampler

This block sits in front of a scaler. It takes a 4:2:2 video stream and turns it into one full Y/Cb/Cr triple per luma sample. The stream arrives in one of two forms, chosen by a mode input. In serial mode each cycle carries one 8-bit sample. In parallel mode each cycle carries one pixel: the luma byte plus one chroma byte.

Every even pixel of a line already has its own Cb and Cr, and the block passes them through. Every odd pixel gets each chroma channel as the rounded mean of the pair to its left and the pair to its right. The last pixel of a line has no right neighbour, so it repeats the left pair.

A valid flag and a frame-start flag travel with the data. An end-of-line flag on the last input beat of each line marks the right edge and restarts the sample phase. Two assumptions hold for the input: line width is even, and valid beats within a line come back to back. Idle cycles may occur between lines.

Top module: `ycc422_to_444`

## Requirements
- R1: While rst_n is low at a clock edge, and after it until the first luma output, out_valid, out_sof and out_data are all zero.
- R2: With par_sel = 0 (serial), samples arrive on in_data[7:0] in the repeating order Cb, Y, Cr, Y. in_data[15:8] is ignored, and exactly one triple is produced per Y sample.
- R3: For an even pixel (the first pixel of each pair), the triple is its own Y with the Cb and Cr of its pair, packed on out_data as Y in [23:16], Cb in [15:8] and Cr in [7:0].
- R4: For an odd pixel that is not the last of its line, each chroma channel equals (left + right + 1) >> 1. Left is the value from the pixel's own pair and right is the value from the next pair.
- R5: For the last pixel of a line (the beat carrying in_eol), each chroma channel repeats the value from its own pair.
- R6: in_sof is given on the first beat of a frame (the Cb beat in serial mode). out_sof is high together with the first triple of that frame and with no other triple.
- R7: out_valid pulses for one cycle per luma-bearing input beat. It stays low for idle cycles and for serial chroma beats.
- R8: The triple for a luma-bearing beat accepted at clock edge k is visible on the outputs after edge k+4, in both modes.
- R9: The sample phase restarts at Cb (serial) or at an even pixel (parallel) on every in_sof and on the first beat after an in_eol, even when the previous line was cut short.
- R10: With par_sel = 1 (parallel), Y is on in_data[15:8] and chroma on in_data[7:0]. Cb is on even pixels and Cr on odd pixels, so Cb comes first in each pair.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| par_sel | input | 1 | 0 = serial 8-bit samples, 1 = parallel Y plus chroma word; held constant during a frame |
| in_valid | input | 1 | Input beat valid |
| in_sof | input | 1 | First beat of a frame |
| in_eol | input | 1 | Last beat of a line |
| in_data | input | 16 | Input sample (serial uses [7:0]) or pixel word (parallel) |
| out_valid | output | 1 | Output triple valid |
| out_sof | output | 1 | First triple of a frame |
| out_data | output | 24 | Triple {Y, Cb, Cr} |

## Verification
The bench drives both bus modes with the following patterns:
- Random lines of several widths, which exercise interior averaging.
- Alternating full-scale chroma (0 and 255), which exposes dropped carries.
- Chroma pairs one step apart, which expose a missing rounding term.
- Minimum two-pixel lines, where the only odd pixel is also the right edge, so repeating and averaging give different results.
- Back-to-back lines with no gap, and lines separated by idle cycles carrying junk data. These separate a correct line-edge restart from one that lets state leak across lines.
- A serial line cut after its Cr sample and followed by a new frame, which shows whether the phase returns to Cb on the frame flag.

// File: rtl/ycc_up_pkg.sv
// Shared definitions for the 4:2:2 to 4:4:4 upsampler.
// Assumes: nothing beyond IEEE 1800-2017 packed types.
package ycc_up_pkg;
    // Number of beats the output tap looks ahead of the current beat.
    localparam int LOOKAHEAD = 3;

    typedef enum logic {
        BUS_SERIAL   = 1'b0,
        BUS_PARALLEL = 1'b1
    } bus_mode_e;

    // Control tag carried alongside every beat through the window.
    typedef struct packed {
        logic       valid;
        logic       sof;
        logic       eol;
        logic [1:0] phase;
    } beat_tag_t;
endpackage

// File: rtl/ycc_up_phase.sv
// Entry phase tracker: labels each incoming beat with its position in the
// pixel pair (serial: 0=Cb 1=Y 2=Cr 3=Y, parallel: 0=even 1=odd).
// Assumes lines start on a Cb sample / even pixel.
module ycc_up_phase
    import ycc_up_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      par_sel,
    input  logic      in_valid,
    input  logic      in_sof,
    input  logic      in_eol,
    output beat_tag_t tag
);
    logic [1:0] ph_q;
    logic [1:0] ph_now;
    logic       fresh_q;

    // Phase of the present beat: restart on frame start or new line.
    always_comb begin
        ph_now = (in_sof || fresh_q) ? 2'd0 : ph_q;
        tag    = '{valid: in_valid, sof: in_sof, eol: in_eol, phase: ph_now};
    end

    // Advance the expected phase and remember whether a line just ended.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q    <= 2'd0;
            fresh_q <= 1'b1;
        end else if (in_valid) begin
            fresh_q <= in_eol;
            if (par_sel == BUS_PARALLEL) begin
                ph_q <= {1'b0, ~ph_now[0]};
            end else begin
                ph_q <= ph_now + 2'd1;
            end
        end
    end
endmodule

// File: rtl/ycc_up_window.sv
// Beat window: a shift line of DEPTH stages that moves every cycle, so the
// stage at DEPTH-1 is the current beat and lower stages are later beats.
// Assumes valid beats inside a line are back to back.
module ycc_up_window
    import ycc_up_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  beat_tag_t                     tag_in,
    input  logic [DATA_W-1:0]             data_in,
    output beat_tag_t [DEPTH-1:0]         tag_q,
    output logic [DEPTH-1:0][DATA_W-1:0]  data_q
);
    // Shift tags and data one stage per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_q  <= '0;
            data_q <= '0;
        end else begin
            tag_q[0]  <= tag_in;
            data_q[0] <= data_in;
            for (int i = 1; i < DEPTH; i++) begin
                tag_q[i]  <= tag_q[i-1];
                data_q[i] <= data_q[i-1];
            end
        end
    end
endmodule

// File: rtl/ycc_up_avg.sv
// Chroma interpolator for one channel: rounded mean of the left and right
// samples, or the left sample alone when no right neighbour exists.
// Assumes unsigned samples.
module ycc_up_avg #(
    parameter int SAMPLE_W = 8
) (
    input  logic [SAMPLE_W-1:0] left,
    input  logic [SAMPLE_W-1:0] right,
    input  logic                use_right,
    output logic [SAMPLE_W-1:0] result
);
    logic [SAMPLE_W:0]   sum;
    logic [SAMPLE_W-1:0] lo_v;
    logic [SAMPLE_W-1:0] hi_v;

    // Round-half-up mean, or repeat of the left value at a line edge.
    always_comb begin
        sum    = {1'b0, left} + {1'b0, right} + {{SAMPLE_W{1'b0}}, 1'b1};
        result = use_right ? sum[SAMPLE_W:1] : left;
    end

    // Bounds for the check below.
    always_comb begin
        lo_v = (left < right) ? left : right;
        hi_v = (left < right) ? right : left;
    end

    // R4: an interpolated value never leaves the span of its neighbours.
    always_comb begin
        a_r4_avg_in_span: assert (result >= lo_v && result <= hi_v)
            else $error("interpolated chroma outside neighbour span");
    end
endmodule

// File: rtl/ycc422_to_444.sv
// 4:2:2 to 4:4:4 chroma upsampler top. Tags each beat with its pair phase,
// holds LOOKAHEAD future beats in a window and builds one {Y,Cb,Cr} triple per
// luma beat with a fixed latency of LOOKAHEAD+1 cycles.
// Assumes even line width, back-to-back beats within a line, par_sel static
// during a frame.
module ycc422_to_444
    import ycc_up_pkg::*;
#(
    parameter int SAMPLE_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  par_sel,
    input  logic                  in_valid,
    input  logic                  in_sof,
    input  logic                  in_eol,
    input  logic [2*SAMPLE_W-1:0] in_data,
    output logic                  out_valid,
    output logic                  out_sof,
    output logic [3*SAMPLE_W-1:0] out_data
);
    localparam int DATA_W = 2 * SAMPLE_W;
    localparam int DEPTH  = LOOKAHEAD + 1;
    localparam int CUR    = DEPTH - 1;
    localparam int NX1    = DEPTH - 2;
    localparam int NX2    = DEPTH - 3;
    localparam int NX3    = DEPTH - 4;

    beat_tag_t                        tag_in;
    beat_tag_t [DEPTH-1:0]            tag_w;
    logic [DEPTH-1:0][DATA_W-1:0]     data_w;
    logic [DEPTH-1:0][SAMPLE_W-1:0]   lo_w;
    beat_tag_t                        cur;

    logic [1:0][SAMPLE_W-1:0] avg_l;
    logic [1:0][SAMPLE_W-1:0] avg_r;
    logic [1:0][SAMPLE_W-1:0] avg_o;

    logic [SAMPLE_W-1:0] hold_cb_q, hold_cb_d;
    logic [SAMPLE_W-1:0] hold_cr_q, hold_cr_d;
    logic                hold_sof_q, hold_sof_d;
    logic                nx_valid, nx_sof;
    logic [SAMPLE_W-1:0] nx_y, nx_cb, nx_cr;

    ycc_up_phase i_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .par_sel  (par_sel),
        .in_valid (in_valid),
        .in_sof   (in_sof),
        .in_eol   (in_eol),
        .tag      (tag_in)
    );

    ycc_up_window #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH)
    ) i_window (
        .clk     (clk),
        .rst_n   (rst_n),
        .tag_in  (tag_in),
        .data_in (in_data),
        .tag_q   (tag_w),
        .data_q  (data_w)
    );

    // Lower byte of every window stage (serial sample or parallel chroma).
    for (genvar g = 0; g < DEPTH; g++) begin : g_lo
        assign lo_w[g] = data_w[g][SAMPLE_W-1:0];
    end

    assign cur = tag_w[CUR];

    // Right neighbours: next Cb is one beat ahead in both modes, next Cr is
    // two beats ahead in parallel and three in serial.
    always_comb begin
        avg_l[0] = hold_cb_q;
        avg_r[0] = lo_w[NX1];
        avg_l[1] = hold_cr_q;
        avg_r[1] = (par_sel == BUS_PARALLEL) ? lo_w[NX2] : lo_w[NX3];
    end

    // One interpolator per chroma channel.
    for (genvar c = 0; c < 2; c++) begin : g_chan
        ycc_up_avg #(.SAMPLE_W(SAMPLE_W)) i_avg (
            .left      (avg_l[c]),
            .right     (avg_r[c]),
            .use_right (!cur.eol),
            .result    (avg_o[c])
        );
    end

    // Decide the triple for the current beat and what the pair holds keep.
    always_comb begin
        nx_valid   = 1'b0;
        nx_sof     = 1'b0;
        nx_y       = lo_w[CUR];
        nx_cb      = '0;
        nx_cr      = '0;
        hold_cb_d  = hold_cb_q;
        hold_cr_d  = hold_cr_q;
        hold_sof_d = hold_sof_q;
        if (cur.valid) begin
            if (par_sel == BUS_PARALLEL) begin
                nx_valid = 1'b1;
                nx_y     = data_w[CUR][DATA_W-1:SAMPLE_W];
                if (!cur.phase[0]) begin
                    nx_cb     = lo_w[CUR];
                    nx_cr     = lo_w[NX1];
                    nx_sof    = cur.sof;
                    hold_cb_d = lo_w[CUR];
                    hold_cr_d = lo_w[NX1];
                end else begin
                    nx_cb = avg_o[0];
                    nx_cr = avg_o[1];
                end
            end else begin
                case (cur.phase)
                    2'd0: begin
                        hold_cb_d  = lo_w[CUR];
                        hold_sof_d = cur.sof;
                    end
                    2'd1: begin
                        nx_valid  = 1'b1;
                        nx_cb     = hold_cb_q;
                        nx_cr     = lo_w[NX1];
                        nx_sof    = hold_sof_q;
                        hold_cr_d = lo_w[NX1];
                    end
                    2'd3: begin
                        nx_valid = 1'b1;
                        nx_cb    = avg_o[0];
                        nx_cr    = avg_o[1];
                    end
                    default: ;
                endcase
            end
        end
    end

    // Register the triple and the pair holds.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_sof    <= 1'b0;
            out_data   <= '0;
            hold_cb_q  <= '0;
            hold_cr_q  <= '0;
            hold_sof_q <= 1'b0;
        end else begin
            out_valid  <= nx_valid;
            out_sof    <= nx_sof;
            out_data   <= nx_valid ? {nx_y, nx_cb, nx_cr} : '0;
            hold_cb_q  <= hold_cb_d;
            hold_cr_q  <= hold_cr_d;
            hold_sof_q <= hold_sof_d;
        end
    end

    // R7: a serial chroma beat at the tap yields no triple.
    a_r7_chroma_beat_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (par_sel == BUS_SERIAL && cur.valid && !cur.phase[0]) |=> !out_valid);

    // R8: every triple traces back to an input beat LOOKAHEAD+2 edges earlier.
    a_r8_fixed_latency: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid, 5));

    // R6: the frame marker never appears without a triple.
    a_r6_sof_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        out_sof |-> out_valid);

    // R9: a frame-start beat enters the window at phase zero.
    a_r9_phase_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sof) |=> (tag_w[0].phase == 2'd0));
endmodule

// File: tb/test_ycc422_to_444.sv
module test_ycc422_to_444;
    localparam int MAXB  = 512;
    localparam int EXTRA = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        par_sel = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_sof = 1'b0;
    logic        in_eol = 1'b0;
    logic [15:0] in_data = '0;
    logic        out_valid;
    logic        out_sof;
    logic [23:0] out_data;

    ycc422_to_444 i_ycc422_to_444 (
        .clk       (clk),
        .rst_n     (rst_n),
        .par_sel   (par_sel),
        .in_valid  (in_valid),
        .in_sof    (in_sof),
        .in_eol    (in_eol),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_sof   (out_sof),
        .out_data  (out_data)
    );

    always #2 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // Stimulus beats and expected outputs, indexed by loop iteration.
    logic        b_v [MAXB];
    logic        b_s [MAXB];
    logic        b_e [MAXB];
    logic [15:0] b_d [MAXB];
    int          nb;
    logic        x_v [MAXB+EXTRA];
    logic        x_s [MAXB+EXTRA];
    logic [23:0] x_d [MAXB+EXTRA];
    string       x_r [MAXB+EXTRA];

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic clear_scn();
        nb = 0;
        for (int i = 0; i < MAXB + EXTRA; i++) begin
            x_v[i] = 1'b0;
            x_s[i] = 1'b0;
            x_d[i] = '0;
            x_r[i] = "R7 idle";
        end
    endtask

    task automatic put(input bit v, input bit s, input bit e, input logic [15:0] d);
        b_v[nb] = v;
        b_s[nb] = s;
        b_e[nb] = e;
        b_d[nb] = d;
        nb++;
    endtask

    // Output for beat idx is visible after edge idx+4, i.e. at iteration idx+5.
    task automatic expect_at(input int idx, input logic [23:0] d, input bit s, input string r);
        x_v[idx+5] = 1'b1;
        x_d[idx+5] = d;
        x_s[idx+5] = s;
        x_r[idx+5] = r;
    endtask

    task automatic add_idle(input int n);
        for (int i = 0; i < n; i++) put(1'b0, 1'b0, 1'b0, 16'($urandom_range(0, 65535)));
    endtask

    // One line of w pixels; kind 0 random, 1 full-scale, 2 one-step chroma.
    task automatic add_line(input bit par, input int w, input bit first, input int kind);
        int yv [64];
        int cbv [32];
        int crv [32];
        for (int j = 0; j < w; j++) yv[j] = (kind == 0) ? $urandom_range(0, 255) : ((j % 2) ? 255 : 0);
        for (int k = 0; k < w / 2; k++) begin
            cbv[k] = (kind == 0) ? $urandom_range(0, 255) : (kind == 1) ? ((k % 2) ? 0 : 255) : 100 + (k % 2);
            crv[k] = (kind == 0) ? $urandom_range(0, 255) : (kind == 1) ? ((k % 2) ? 255 : 0) : (k % 2);
        end
        for (int j = 0; j < w; j++) begin
            int k = j / 2;
            int ecb;
            int ecr;
            string pt;
            if (j % 2 == 0 || j == w - 1) begin
                ecb = cbv[k];
                ecr = crv[k];
            end else begin
                ecb = (cbv[k] + cbv[k+1] + 1) / 2;
                ecr = (crv[k] + crv[k+1] + 1) / 2;
            end
            pt = (first && j == 0) ? "R6 R3" : (j % 2 == 0) ? "R3" : (j == w - 1) ? "R5" : "R4";
            pt = {(par ? "R10 " : "R2 "), pt, " R8"};
            if (par) begin
                expect_at(nb, {8'(yv[j]), 8'(ecb), 8'(ecr)}, first && j == 0, pt);
                put(1'b1, first && j == 0, j == w - 1,
                    {8'(yv[j]), (j % 2 == 0) ? 8'(cbv[k]) : 8'(crv[k])});
            end else begin
                if (j % 2 == 0) put(1'b1, first && j == 0, 1'b0, {8'($urandom_range(0, 255)), 8'(cbv[k])});
                expect_at(nb, {8'(yv[j]), 8'(ecb), 8'(ecr)}, first && j == 0, pt);
                put(1'b1, 1'b0, j == w - 1, {8'($urandom_range(0, 255)), 8'(yv[j])});
                if (j % 2 == 0) put(1'b1, 1'b0, 1'b0, {8'($urandom_range(0, 255)), 8'(crv[k])});
            end
        end
    endtask

    // Serial line cut after its first Cr sample, with no end-of-line flag.
    task automatic add_fragment();
        logic [7:0] cb = 8'd37;
        logic [7:0] y  = 8'd200;
        logic [7:0] cr = 8'd90;
        put(1'b1, 1'b0, 1'b0, {8'h5a, cb});
        expect_at(nb, {y, cb, cr}, 1'b0, "R9 R2 R3");
        put(1'b1, 1'b0, 1'b0, {8'ha5, y});
        put(1'b1, 1'b0, 1'b0, {8'h3c, cr});
    endtask

    task automatic run_scn(input bit par);
        @(negedge clk);
        par_sel = par;
        for (int i = 0; i < nb + EXTRA; i++) begin
            @(negedge clk);
            if (x_v[i]) begin
                chk(out_valid === 1'b1, {x_r[i], " valid"}, 32'(out_valid), 32'd1);
                chk(out_data === x_d[i], {x_r[i], " data"}, 32'(out_data), 32'(x_d[i]));
                chk(out_sof === x_s[i], {x_r[i], " R6 sof"}, 32'(out_sof), 32'(x_s[i]));
            end else begin
                chk(out_valid === 1'b0 && out_sof === 1'b0, {x_r[i], " no output"},
                    32'({out_valid, out_sof}), 32'd0);
            end
            if (i < nb) begin
                in_valid = b_v[i];
                in_sof   = b_s[i];
                in_eol   = b_e[i];
                in_data  = b_d[i];
            end else begin
                in_valid = 1'b0;
                in_sof   = 1'b0;
                in_eol   = 1'b0;
                in_data  = 16'($urandom_range(0, 65535));
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(out_valid === 1'b0 && out_sof === 1'b0 && out_data === 24'd0, "R1 in reset",
            32'({out_valid, out_sof, out_data}), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid === 1'b0 && out_sof === 1'b0 && out_data === 24'd0, "R1 after reset",
            32'({out_valid, out_sof, out_data}), 32'd0);

        // Parallel, random data, gaps and back-to-back lines.
        clear_scn();
        add_line(1'b1, 8, 1'b1, 0);
        add_idle(3);
        add_line(1'b1, 8, 1'b0, 0);
        add_line(1'b1, 6, 1'b0, 0);
        add_idle(2);
        add_line(1'b1, 4, 1'b1, 0);
        run_scn(1'b1);

        // Serial, random data, two frames.
        clear_scn();
        add_line(1'b0, 6, 1'b1, 0);
        add_idle(4);
        add_line(1'b0, 4, 1'b0, 0);
        add_line(1'b0, 8, 1'b1, 0);
        run_scn(1'b0);

        // Parallel full-scale and rounding patterns, minimum width line.
        clear_scn();
        add_line(1'b1, 6, 1'b1, 1);
        add_line(1'b1, 6, 1'b0, 2);
        add_idle(1);
        add_line(1'b1, 2, 1'b0, 0);
        run_scn(1'b1);

        // Serial full-scale and rounding patterns, minimum width line.
        clear_scn();
        add_line(1'b0, 6, 1'b1, 1);
        add_line(1'b0, 4, 1'b0, 2);
        add_idle(2);
        add_line(1'b0, 2, 1'b0, 0);
        run_scn(1'b0);

        // R9: serial line cut mid-pair, then a new frame.
        clear_scn();
        add_fragment();
        add_idle(3);
        add_line(1'b0, 4, 1'b1, 0);
        run_scn(1'b0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule